// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small set of hardware ownership flags that two independent ports share. It sits beside a shared memory but has no storage of its own besides the flags. Each port has its own flag-access strobe and its own output enable. It also has a direction bit, an address bus whose three low bits pick one of eight flags, a single write bit and a registered read bus. A flag is claimed by writing 0 and given back by writing 1. A port reads 0 from a flag it owns and 1 from a flag it does not own.

Every flag keeps a request latch for each side. A side that writes 0 while the other side holds the flag waits in its latch. The flag passes to the waiting side on the same clock edge at which the holder writes 1. If both sides claim a free flag on the same edge, the left side wins and the right side's claim waits. Software frees every flag at start-up by writing 1 from both sides. A synchronous reset also clears all latches, so the bank starts with every flag free.

Top module: `sem_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every flag is free and both read buses show all ones.
- R2: A port takes part in flag access only while its flag strobe (`*_sel`) is 1 and its memory enable (`*_mem_en`) is 0. A write made with the strobe at 0, or with the memory enable at 1, changes no flag.
- R3: A write of `*_wbit`=0 with `*_wr`=1 to a free flag makes the writer the owner. From then on the owner reads 0 and the other port reads 1.
- R4: A write of 0 by the non-owner does not change the owner. The owner keeps reading 0 and the other port keeps reading 1.
- R5: When the owner writes 1 while the other side has a request waiting, the other side becomes owner at that same clock edge.
- R6: When the owner writes 1 and no request is waiting, the flag becomes free and both ports read 1.
- R7: When both ports write 0 to the same free flag in the same cycle, the left port becomes owner and the right port's request waits. The right port takes the flag when the left port releases it.
- R8: A read drives the flag value onto every bit of the `DATA_W`-bit read bus: all zeros or all ones.
- R9: A read (`*_wr`=0, `*_oe`=1) loads the read register on its first cycle. While the read stays asserted, the register keeps that value, even if the other port changes the flag.
- R10: Only address bits [2:0] select the flag. Higher address bits have no effect on reads or writes.
- R11: With `*_oe`=0, a read access does not load the read register, so the bus keeps its previous value.
- R12: A write of 1 by a side that only has a request waiting cancels that request. A later release by the owner then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_sel | input | 1 | Left flag-access strobe |
| lf_mem_en | input | 1 | Left memory enable; blocks flag access when 1 |
| lf_oe | input | 1 | Left output enable for reads |
| lf_wr | input | 1 | Left direction: 1 write, 0 read |
| lf_addr | input | ADDR_W | Left address; bits [2:0] select the flag |
| lf_wbit | input | 1 | Left write value: 0 claim, 1 release |
| lf_rdata | output | DATA_W | Left registered read value |
| rt_sel | input | 1 | Right flag-access strobe |
| rt_mem_en | input | 1 | Right memory enable; blocks flag access when 1 |
| rt_oe | input | 1 | Right output enable for reads |
| rt_wr | input | 1 | Right direction: 1 write, 0 read |
| rt_addr | input | ADDR_W | Right address; bits [2:0] select the flag |
| rt_wbit | input | 1 | Right write value: 0 claim, 1 release |
| rt_rdata | output | DATA_W | Right registered read value |

## Verification
A wrong owner or a lost request latch stays hidden until a port reads. It then shows up one clock after the read starts, as a 0 or 1 on the read bus that breaks the ownership rules. Either both sides see ownership, or a waiting side still reads 1 after the holder's release. Each scenario therefore ends with reads from both sides. A cancelled or blocked request can only be seen through a later action, such as a release or a claim by the other side. For that reason those cases use a follow-up action and then a read. A read register that wrongly reloads during a held read is caught on the second and third cycle of that read, after the other port has changed the flag.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int SEM_COUNT = 8;
    localparam int SEM_IDX_W = $clog2(SEM_COUNT);

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_LF   = 2'd1,
        OWN_RT   = 2'd2
    } owner_e;

    // One port's decoded flag operation for the current cycle.
    typedef struct packed {
        logic                 wr;
        logic                 rd;
        logic [SEM_IDX_W-1:0] idx;
        logic                 val;
    } sem_op_t;

    // The current owner keeps the flag while its request stands;
    // otherwise the left request has priority over the right one.
    function automatic owner_e next_owner(owner_e cur, logic want_lf, logic want_rt);
        if (cur == OWN_LF && want_lf) return OWN_LF;
        if (cur == OWN_RT && want_rt) return OWN_RT;
        if (want_lf)                  return OWN_LF;
        if (want_rt)                  return OWN_RT;
        return OWN_NONE;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
(
    input  logic                 sel,
    input  logic                 mem_en,
    input  logic                 oe,
    input  logic                 wr,
    input  logic [SEM_IDX_W-1:0] idx,
    input  logic                 wbit,
    output sem_op_t              op
);
    logic acc;

    always_comb begin
        acc    = sel & ~mem_en;
        op.wr  = acc & wr;
        op.rd  = acc & ~wr & oe;
        op.idx = idx;
        op.val = wbit;
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  sem_op_t lf_op,
    input  sem_op_t rt_op,
    output owner_e  owner,
    output logic    want_lf,
    output logic    want_rt
);
    localparam logic [SEM_IDX_W-1:0] MY_IDX = SEM_IDX_W'(IDX);

    logic hit_lf, hit_rt;
    logic want_lf_n, want_rt_n;

    always_comb begin
        hit_lf    = lf_op.wr && (lf_op.idx == MY_IDX);
        hit_rt    = rt_op.wr && (rt_op.idx == MY_IDX);
        want_lf_n = hit_lf ? ~lf_op.val : want_lf;
        want_rt_n = hit_rt ? ~rt_op.val : want_rt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner   <= OWN_NONE;
            want_lf <= 1'b0;
            want_rt <= 1'b0;
        end else begin
            owner   <= next_owner(owner, want_lf_n, want_rt_n);
            want_lf <= want_lf_n;
            want_rt <= want_rt_n;
        end
    end
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port
    import sem_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sem_op_t              op,
    input  logic [SEM_COUNT-1:0] view,
    output logic [DATA_W-1:0]    rdata
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            rdata <= '1;
        end else begin
            rd_q <= op.rd;
            if (op.rd && !rd_q)
                rdata <= {DATA_W{view[op.idx]}};
        end
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lf_sel,
    input  logic              lf_mem_en,
    input  logic              lf_oe,
    input  logic              lf_wr,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic              lf_wbit,
    output logic [DATA_W-1:0] lf_rdata,
    input  logic              rt_sel,
    input  logic              rt_mem_en,
    input  logic              rt_oe,
    input  logic              rt_wr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_wbit,
    output logic [DATA_W-1:0] rt_rdata
);
    localparam int IDX_W = SEM_IDX_W;

    sem_op_t              lf_op, rt_op;
    owner_e               sem_own [SEM_COUNT];
    logic [SEM_COUNT-1:0] own_l, own_r, want_l, want_r;
    logic [SEM_COUNT-1:0] view_l, view_r;

    logic unused_addr_hi;
    assign unused_addr_hi = ^{lf_addr[ADDR_W-1:IDX_W], rt_addr[ADDR_W-1:IDX_W]};

    sem_port_decode u_dec_lf (
        .sel(lf_sel), .mem_en(lf_mem_en), .oe(lf_oe), .wr(lf_wr),
        .idx(lf_addr[IDX_W-1:0]), .wbit(lf_wbit), .op(lf_op)
    );
    sem_port_decode u_dec_rt (
        .sel(rt_sel), .mem_en(rt_mem_en), .oe(rt_oe), .wr(rt_wr),
        .idx(rt_addr[IDX_W-1:0]), .wbit(rt_wbit), .op(rt_op)
    );

    for (genvar i = 0; i < SEM_COUNT; i++) begin : g_cell
        sem_cell #(.IDX(i)) u_cell (
            .clk(clk), .rst(rst), .lf_op(lf_op), .rt_op(rt_op),
            .owner(sem_own[i]), .want_lf(want_l[i]), .want_rt(want_r[i])
        );
        assign own_l[i]  = (sem_own[i] == OWN_LF);
        assign own_r[i]  = (sem_own[i] == OWN_RT);
        assign view_l[i] = ~own_l[i];
        assign view_r[i] = ~own_r[i];
    end

    sem_rd_port #(.DATA_W(DATA_W)) u_rd_lf (
        .clk(clk), .rst(rst), .op(lf_op), .view(view_l), .rdata(lf_rdata)
    );
    sem_rd_port #(.DATA_W(DATA_W)) u_rd_rt (
        .clk(clk), .rst(rst), .op(rt_op), .view(view_r), .rdata(rt_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lf_sel,
    input logic                 lf_mem_en,
    input logic                 lf_oe,
    input logic                 lf_wr,
    input logic [ADDR_W-1:0]    lf_addr,
    input logic                 lf_wbit,
    input logic [DATA_W-1:0]    lf_rdata,
    input logic                 rt_sel,
    input logic                 rt_mem_en,
    input logic                 rt_oe,
    input logic                 rt_wr,
    input logic [ADDR_W-1:0]    rt_addr,
    input logic                 rt_wbit,
    input logic [DATA_W-1:0]    rt_rdata,
    input logic [SEM_COUNT-1:0] own_l,
    input logic [SEM_COUNT-1:0] own_r,
    input logic [SEM_COUNT-1:0] want_r
);
    logic acc_l, acc_r, rd_l, rd_r, rst_q;

    assign acc_l = lf_sel && !lf_mem_en;
    assign acc_r = rt_sel && !rt_mem_en;
    assign rd_l  = acc_l && !lf_wr && lf_oe;
    assign rd_r  = acc_r && !rt_wr && rt_oe;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: read buses idle at all ones right after reset
    a_r1_reset_ones: assert property (@(posedge clk)
        (rst_q && !rst) |-> (lf_rdata == '1 && rt_rdata == '1));

    // R8: every bit carries the same flag value
    a_r8_lf_replicated: assert property (@(posedge clk) disable iff (rst)
        (lf_rdata == '0 || lf_rdata == '1));
    a_r8_rt_replicated: assert property (@(posedge clk) disable iff (rst)
        (rt_rdata == '0 || rt_rdata == '1));

    // R9: a held read keeps the captured value
    a_r9_lf_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_l && $past(rd_l) && !$past(rst)) |=> $stable(lf_rdata));
    a_r9_rt_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_r && $past(rd_r) && !$past(rst)) |=> $stable(rt_rdata));

    // R2: without access on either port no ownership moves
    a_r2_blocked: assert property (@(posedge clk) disable iff (rst)
        (!acc_l && !acc_r) |=> ($stable(own_l) && $stable(own_r)));

    for (genvar i = 0; i < SEM_COUNT; i++) begin : g_sem
        logic wl, wr_, rel_l, rel_r, clm_l, clm_r;
        assign wl    = acc_l && lf_wr && (lf_addr[SEM_IDX_W-1:0] == SEM_IDX_W'(i));
        assign wr_   = acc_r && rt_wr && (rt_addr[SEM_IDX_W-1:0] == SEM_IDX_W'(i));
        assign rel_l = wl && lf_wbit;
        assign rel_r = wr_ && rt_wbit;
        assign clm_l = wl && !lf_wbit;
        assign clm_r = wr_ && !rt_wbit;

        // R4: an owner keeps the flag until it releases
        a_r4_lf_keeps: assert property (@(posedge clk) disable iff (rst)
            (own_l[i] && !rel_l) |=> own_l[i]);
        a_r4_rt_keeps: assert property (@(posedge clk) disable iff (rst)
            (own_r[i] && !rel_r) |=> own_r[i]);

        // R5: release hands the flag to a waiting right side
        a_r5_handoff: assert property (@(posedge clk) disable iff (rst)
            (own_l[i] && rel_l && want_r[i] && !wr_) |=> own_r[i]);

        // R7: simultaneous claim on a free flag goes left
        a_r7_left_wins: assert property (@(posedge clk) disable iff (rst)
            (!own_l[i] && !own_r[i] && clm_l && clm_r) |=> (own_l[i] && !own_r[i]));
    end
endmodule

bind sem_bank sem_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .lf_sel(lf_sel), .lf_mem_en(lf_mem_en), .lf_oe(lf_oe), .lf_wr(lf_wr),
    .lf_addr(lf_addr), .lf_wbit(lf_wbit), .lf_rdata(lf_rdata),
    .rt_sel(rt_sel), .rt_mem_en(rt_mem_en), .rt_oe(rt_oe), .rt_wr(rt_wr),
    .rt_addr(rt_addr), .rt_wbit(rt_wbit), .rt_rdata(rt_rdata),
    .own_l(own_l), .own_r(own_r), .want_r(want_r)
);

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 9;
    localparam logic [DATA_W-1:0] ONES  = '1;
    localparam logic [DATA_W-1:0] ZEROS = '0;

    logic clk = 1'b0;
    logic rst;
    logic              lf_sel, lf_mem_en, lf_oe, lf_wr, lf_wbit;
    logic [ADDR_W-1:0] lf_addr;
    logic [DATA_W-1:0] lf_rdata;
    logic              rt_sel, rt_mem_en, rt_oe, rt_wr, rt_wbit;
    logic [ADDR_W-1:0] rt_addr;
    logic [DATA_W-1:0] rt_rdata;

    always #4 clk = ~clk;

    sem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sem_bank (
        .clk(clk), .rst(rst),
        .lf_sel(lf_sel), .lf_mem_en(lf_mem_en), .lf_oe(lf_oe), .lf_wr(lf_wr),
        .lf_addr(lf_addr), .lf_wbit(lf_wbit), .lf_rdata(lf_rdata),
        .rt_sel(rt_sel), .rt_mem_en(rt_mem_en), .rt_oe(rt_oe), .rt_wr(rt_wr),
        .rt_addr(rt_addr), .rt_wbit(rt_wbit), .rt_rdata(rt_rdata)
    );

    typedef struct {
        int                due;
        bit                port;
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares read results in the cycle they are due.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, it.port ? rt_rdata : lf_rdata, it.exp);
        end
    end

    task automatic set_port(bit p, logic sel, logic mem, logic oe, logic wr,
                            logic [ADDR_W-1:0] a, logic wb);
        if (!p) begin
            lf_sel = sel; lf_mem_en = mem; lf_oe = oe; lf_wr = wr; lf_addr = a; lf_wbit = wb;
        end else begin
            rt_sel = sel; rt_mem_en = mem; rt_oe = oe; rt_wr = wr; rt_addr = a; rt_wbit = wb;
        end
    endtask

    task automatic idle_all();
        set_port(0, 0, 0, 0, 0, '0, 1);
        set_port(1, 0, 0, 0, 0, '0, 1);
    endtask

    task automatic wr(bit p, logic [ADDR_W-1:0] a, logic wb);
        idle_all();
        set_port(p, 1, 0, 0, 1, a, wb);
        @(negedge clk);
        idle_all();
    endtask

    task automatic rd(bit p, logic [ADDR_W-1:0] a, logic oe,
                      logic [DATA_W-1:0] exp, string tag);
        idle_all();
        set_port(p, 1, 0, oe, 0, a, 1);
        q.push_back('{due: cyc + 1, port: p, exp: exp, tag: tag});
        @(negedge clk);
        idle_all();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_all();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 left reset", lf_rdata, ONES);
        check("R1 right reset", rt_rdata, ONES);
        rst = 1'b0;

        // start-up: free all flags from both sides
        for (int i = 0; i < 8; i++) begin
            wr(0, ADDR_W'(i), 1);
            wr(1, ADDR_W'(i), 1);
        end
        rd(0, 12'h000, 1, ONES, "R6 free after init");

        // R3 and R8: claim a free flag
        wr(0, 12'h000, 0);
        rd(0, 12'h000, 1, ZEROS, "R3/R8 owner reads all zeros");
        rd(1, 12'h000, 1, ONES, "R3/R8 other reads all ones");

        // R4: non-owner claim leaves owner in place
        wr(1, 12'h000, 0);
        rd(0, 12'h000, 1, ZEROS, "R4 owner kept");
        rd(1, 12'h000, 1, ONES, "R4 waiter not owner");

        // R5: release hands over to the waiter
        wr(0, 12'h000, 1);
        rd(1, 12'h000, 1, ZEROS, "R5 waiter now owner");
        rd(0, 12'h000, 1, ONES, "R5 old owner reads one");

        // R6: release with nobody waiting
        wr(1, 12'h000, 1);
        rd(0, 12'h000, 1, ONES, "R6 left free");
        rd(1, 12'h000, 1, ONES, "R6 right free");

        // R7: simultaneous claim
        idle_all();
        set_port(0, 1, 0, 0, 1, 12'h001, 0);
        set_port(1, 1, 0, 0, 1, 12'h001, 0);
        @(negedge clk);
        idle_all();
        rd(0, 12'h001, 1, ZEROS, "R7 left wins");
        rd(1, 12'h001, 1, ONES, "R7 right waits");
        wr(0, 12'h001, 1);
        rd(1, 12'h001, 1, ZEROS, "R7 right gets flag after release");
        wr(1, 12'h001, 1);

        // R10: upper address bits ignored
        wr(0, 12'hFA3, 0);
        rd(0, 12'h003, 1, ZEROS, "R10 claim via high bits");
        rd(1, 12'h7B3, 1, ONES, "R10 other side aliased read");
        wr(0, 12'h013, 1);
        rd(1, 12'h003, 1, ONES, "R10 release via other alias");

        // R2: blocked writes have no effect
        idle_all();
        set_port(0, 1, 1, 0, 1, 12'h004, 0);
        @(negedge clk);
        idle_all();
        wr(1, 12'h004, 0);
        rd(1, 12'h004, 1, ZEROS, "R2 mem_en blocked left claim");
        wr(1, 12'h004, 1);
        idle_all();
        set_port(0, 0, 0, 0, 1, 12'h005, 0);
        @(negedge clk);
        idle_all();
        wr(1, 12'h005, 0);
        rd(1, 12'h005, 1, ZEROS, "R2 sel low blocked left claim");
        wr(1, 12'h005, 1);

        // R12: waiter cancels, release leaves flag free
        wr(0, 12'h006, 0);
        wr(1, 12'h006, 0);
        wr(1, 12'h006, 1);
        wr(0, 12'h006, 1);
        rd(1, 12'h006, 1, ONES, "R12 cancelled request not granted");
        rd(0, 12'h006, 1, ONES, "R12 flag free");

        // R9: held read ignores a change by the other side
        wr(1, 12'h002, 0);
        wr(0, 12'h002, 0);
        idle_all();
        set_port(0, 1, 0, 1, 0, 12'h002, 1);
        q.push_back('{due: cyc + 1, port: 0, exp: ONES, tag: "R9 first capture"});
        @(negedge clk);
        set_port(1, 1, 0, 0, 1, 12'h002, 1);
        @(negedge clk);
        set_port(1, 0, 0, 0, 0, 12'h000, 1);
        q.push_back('{due: cyc + 1, port: 0, exp: ONES, tag: "R9 value held"});
        @(negedge clk);
        idle_all();
        @(negedge clk);
        rd(0, 12'h002, 1, ZEROS, "R9 new read sees handoff");

        // R11: read without output enable does not reload
        rd(0, 12'h007, 0, ZEROS, "R11 oe low keeps old value");
        wr(0, 12'h002, 1);
        rd(0, 12'h007, 1, ONES, "R11 oe high reloads");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule